// File: doc/BRIEF.md
# Serial Receiver with Character Queue

This block takes an asynchronous serial line that idles high and turns it into characters in a 16-entry receive queue. A sample-enable pulse from an external baud generator marks each oversampling tick, 16 per bit by default. The receiver waits for a falling edge and confirms the start bit at its centre. It then shifts in 7 or 8 data bits least significant bit first, samples an optional parity bit and one or two stop bits. Each completed character is written into the queue together with its own parity-error and framing-error bits.

A character is refused when the line is in a break, when an overrun is pending, or when the queue is full. Parity and framing errors do not refuse a character. They only mark the entry and set a sticky error flag, and reception goes on. Break and overrun are sticky flags. While either flag is set, every new character is dropped. Each flag has its own clear pulse.

Three level interrupt lines come from the flags. Data-full is gated by the receive enable. Receive-error and break/overrun are each raised when either the receive enable or the error enable is set.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the queue is empty (count 0), all status flags are 0 and all three interrupt lines are 0.
- R2: Data bits are taken least significant bit first. With cfg_len8=1 eight bits are stored. With cfg_len8=0 seven bits are stored in rd_data[6:0] and rd_data[7] reads 0.
- R3: A low level on the line that is high again at the centre of the start bit (8 ticks after the falling edge) starts no character and changes no state.
- R4: With cfg_par_en=1 a parity bit follows the data. Parity is even when cfg_par_odd=0 and odd when cfg_par_odd=1. A mismatch stores the character with rd_perr=1 and sets st_err. The next character is still received normally.
- R5: Only the first stop bit is checked. If it is 0, the character is stored with rd_ferr=1 and st_err is set. With cfg_stop2=1 a 0 in the second stop bit has no effect.
- R6: A character whose data, parity and first stop bit are all 0 sets st_brk and is not stored. While st_brk=1 all characters are discarded. A clr_brk pulse clears st_brk.
- R7: A character that completes while the queue holds 16 entries is discarded and sets st_ovr. The queued entries stay intact. While st_ovr=1 all characters are discarded, even when space is free. A clr_ovr pulse clears st_ovr.
- R8: st_full is 1 exactly when fifo_count is at least the trigger level selected by cfg_trig: 0→1, 1→4, 2→8, 3→14.
- R9: st_ready is 1 when the queue is not empty and the receiver has been idle for at least 2 bit times (32 ticks). It is 0 at the end of the stop bit of a just-received character.
- R10: irq_rxfull = ie_rx AND (st_full OR st_ready).
- R11: irq_rxerr = (ie_rx OR ie_err) AND st_err. A clr_err pulse clears st_err.
- R12: irq_brk = (ie_rx OR ie_err) AND (st_brk OR st_ovr).
- R13: Entries leave in arrival order. rd_data, rd_perr and rd_ferr always show the oldest entry, and a rd_en pulse removes it. rd_en on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Oversampling tick (OVS per bit) |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_trig | input | 2 | Data-full trigger level select |
| ie_rx | input | 1 | Receive interrupt enable |
| ie_err | input | 1 | Receive-error interrupt enable |
| rd_en | input | 1 | Pop oldest entry |
| clr_err | input | 1 | Clear error flag |
| clr_brk | input | 1 | Clear break flag |
| clr_ovr | input | 1 | Clear overrun flag |
| rd_data | output | 8 | Oldest entry data |
| rd_perr | output | 1 | Oldest entry parity error |
| rd_ferr | output | 1 | Oldest entry framing error |
| fifo_count | output | 5 | Entries held |
| st_ready | output | 1 | Data-ready flag |
| st_full | output | 1 | Count at or above trigger |
| st_err | output | 1 | Sticky parity/framing error |
| st_brk | output | 1 | Sticky break |
| st_ovr | output | 1 | Sticky overrun |
| irq_rxfull | output | 1 | Data-full interrupt |
| irq_rxerr | output | 1 | Receive-error interrupt |
| irq_brk | output | 1 | Break/overrun interrupt |

## Verification
The bench builds the block with its defaults: a 16-entry queue and 16 ticks per bit. It holds sample_en high, so one bit lasts 16 clocks and a full character about 160. At that rate all 256 byte values can be swept in 8-bit mode, and all 128 values in 7-bit even-parity mode with two stop bits. The queue can also be filled to 16 entries one level at a time, so that each of the four trigger levels is checked at every count and the overrun occurs on the seventeenth character. Break, framing errors on each stop bit and wrong parity are driven as single frames, and each is followed by a good frame to show whether reception continues or is blocked.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int DW = 8;

  typedef struct packed {
    logic          perr;
    logic          ferr;
    logic [DW-1:0] data;
  } rx_entry_t;

  localparam int EW = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_e;

  function automatic int trig_level(input logic [1:0] code, input int depth);
    int lvl;
    case (code)
      2'd0:    lvl = 1;
      2'd1:    lvl = 4;
      2'd2:    lvl = 8;
      default: lvl = 14;
    endcase
    return (lvl > depth) ? depth : lvl;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_n;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic          rx_s,
  input  logic          cfg_len8,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_stop2,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o,
  output logic          idle_o
);
  localparam int CNTW = $clog2(OVS);
  localparam logic [CNTW-1:0] LAST = CNTW'(OVS - 1);
  localparam logic [CNTW-1:0] HALF = CNTW'(OVS / 2 - 1);

  rx_state_e       st_q, st_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [2:0]      idx_q, idx_n;
  logic [DW-1:0]   sh_q, sh_n;
  logic            par_q, par_n;
  logic            zero_q, zero_n;
  logic            perr_q, perr_n;
  logic            ferr_q, ferr_n;
  logic            brk_q, brk_n;
  logic            done_q, done_n;
  logic [2:0]      last_idx;

  assign last_idx = cfg_len8 ? 3'd7 : 3'd6;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    par_n  = par_q;
    zero_n = zero_q;
    perr_n = perr_q;
    ferr_n = ferr_q;
    brk_n  = brk_q;
    done_n = 1'b0;
    if (sample_en) begin
      unique case (st_q)
        S_IDLE: begin
          if (!rx_s) begin
            st_n  = S_START;
            cnt_n = '0;
          end
        end
        S_START: begin
          if (cnt_q == HALF) begin
            cnt_n = '0;
            if (rx_s) begin
              st_n = S_IDLE;
            end else begin
              st_n   = S_DATA;
              idx_n  = '0;
              sh_n   = '0;
              par_n  = 1'b0;
              zero_n = 1'b1;
              perr_n = 1'b0;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == LAST) begin
            cnt_n = '0;
            unique case (st_q)
              S_DATA: begin
                sh_n   = {rx_s, sh_q[DW-1:1]};
                par_n  = par_q ^ rx_s;
                zero_n = zero_q & ~rx_s;
                idx_n  = idx_q + 1'b1;
                if (idx_q == last_idx) st_n = cfg_par_en ? S_PAR : S_STOP1;
              end
              S_PAR: begin
                perr_n = par_q ^ rx_s ^ cfg_par_odd;
                zero_n = zero_q & ~rx_s;
                st_n   = S_STOP1;
              end
              S_STOP1: begin
                done_n = 1'b1;
                ferr_n = ~rx_s;
                brk_n  = zero_q & ~rx_s;
                st_n   = cfg_stop2 ? S_STOP2 : S_IDLE;
              end
              default: st_n = S_IDLE;
            endcase
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      zero_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      brk_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      par_q  <= par_n;
      zero_q <= zero_n;
      perr_q <= perr_n;
      ferr_q <= ferr_n;
      brk_q  <= brk_n;
      done_q <= done_n;
    end
  end

  assign done_o = done_q;
  assign data_o = cfg_len8 ? sh_q : {1'b0, sh_q[DW-1:1]};
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
  assign brk_o  = brk_q;
  assign idle_o = (st_q == S_IDLE);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_en,
  input  logic                       rxd_i,
  input  logic                       cfg_len8,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_odd,
  input  logic                       cfg_stop2,
  input  logic [1:0]                 cfg_trig,
  input  logic                       ie_rx,
  input  logic                       ie_err,
  input  logic                       rd_en,
  input  logic                       clr_err,
  input  logic                       clr_brk,
  input  logic                       clr_ovr,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_perr,
  output logic                       rd_ferr,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       st_ready,
  output logic                       st_full,
  output logic                       st_err,
  output logic                       st_brk,
  output logic                       st_ovr,
  output logic                       irq_rxfull,
  output logic                       irq_rxerr,
  output logic                       irq_brk
);
  localparam int CW         = $clog2(DEPTH + 1);
  localparam int IDLE_TICKS = OVS * IDLE_BITS;
  localparam int ICW        = $clog2(IDLE_TICKS + 1);

  logic          rx_s;
  logic          frm_done, frm_perr, frm_ferr, frm_brk, frm_idle;
  logic [DW-1:0] frm_data;
  rx_entry_t     wr_entry, rd_entry;
  logic          push;
  logic          q_full;
  logic [CW-1:0] count;
  logic          err_q, err_n, brk_q, brk_n, ovr_q, ovr_n;
  logic [ICW-1:0] idle_q, idle_n;
  logic          blocked;

  srx_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  srx_framer #(.OVS(OVS)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (sample_en),
    .rx_s        (rx_s),
    .cfg_len8    (cfg_len8),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_stop2   (cfg_stop2),
    .done_o      (frm_done),
    .data_o      (frm_data),
    .perr_o      (frm_perr),
    .ferr_o      (frm_ferr),
    .brk_o       (frm_brk),
    .idle_o      (frm_idle)
  );

  assign q_full   = (count == CW'(DEPTH));
  assign blocked  = brk_q | ovr_q;
  assign push     = frm_done & ~frm_brk & ~blocked & ~q_full;
  assign wr_entry = '{perr: frm_perr, ferr: frm_ferr, data: frm_data};

  srx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (wr_entry),
    .pop   (rd_en),
    .rdata (rd_entry),
    .count (count)
  );

  always_comb begin
    err_n  = err_q;
    brk_n  = brk_q;
    ovr_n  = ovr_q;
    idle_n = idle_q;
    if (clr_err) err_n = 1'b0;
    if (clr_brk) brk_n = 1'b0;
    if (clr_ovr) ovr_n = 1'b0;
    if (frm_done) begin
      if (frm_brk) brk_n = 1'b1;
      else begin
        if (frm_perr | frm_ferr) err_n = 1'b1;
        if (!blocked && q_full)  ovr_n = 1'b1;
      end
    end
    if (!frm_idle) idle_n = '0;
    else if (sample_en && idle_q != ICW'(IDLE_TICKS)) idle_n = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      brk_q  <= 1'b0;
      ovr_q  <= 1'b0;
      idle_q <= '0;
    end else begin
      err_q  <= err_n;
      brk_q  <= brk_n;
      ovr_q  <= ovr_n;
      idle_q <= idle_n;
    end
  end

  assign rd_data    = rd_entry.data;
  assign rd_perr    = rd_entry.perr;
  assign rd_ferr    = rd_entry.ferr;
  assign fifo_count = count;
  assign st_full    = (count >= CW'(trig_level(cfg_trig, DEPTH)));
  assign st_ready   = (count != '0) && (idle_q == ICW'(IDLE_TICKS));
  assign st_err     = err_q;
  assign st_brk     = brk_q;
  assign st_ovr     = ovr_q;
  assign irq_rxfull = ie_rx & (st_full | st_ready);
  assign irq_rxerr  = (ie_rx | ie_err) & err_q;
  assign irq_brk    = (ie_rx | ie_err) & (brk_q | ovr_q);
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ie_rx,
  input logic                       ie_err,
  input logic                       rd_en,
  input logic                       clr_brk,
  input logic                       clr_ovr,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       st_ready,
  input logic                       st_full,
  input logic                       st_err,
  input logic                       st_brk,
  input logic                       st_ovr,
  input logic                       irq_rxfull,
  input logic                       irq_rxerr,
  input logic                       irq_brk
);
  localparam int CW = $clog2(DEPTH + 1);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovr && !clr_ovr) |=> st_ovr);

  assert_brk_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_brk && !clr_brk) |=> st_brk);

  assert_brk_no_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_brk && !rd_en) |=> (fifo_count <= $past(fifo_count)));

  assert_ready_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> (fifo_count != '0));

  assert_full_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> (fifo_count != '0));

  assert_irq_full_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxfull |-> (ie_rx && (st_full || st_ready)));

  assert_irq_err_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxerr |-> ((ie_rx || ie_err) && st_err));

  assert_irq_brk_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_brk |-> ((ie_rx || ie_err) && (st_brk || st_ovr)));

  assert_pop_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |=> (fifo_count <= CW'(1)));
endmodule

bind serial_rx_fifo srx_checker #(.DEPTH(DEPTH)) u_srx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ie_rx      (ie_rx),
  .ie_err     (ie_err),
  .rd_en      (rd_en),
  .clr_brk    (clr_brk),
  .clr_ovr    (clr_ovr),
  .fifo_count (fifo_count),
  .st_ready   (st_ready),
  .st_full    (st_full),
  .st_err     (st_err),
  .st_brk     (st_brk),
  .st_ovr     (st_ovr),
  .irq_rxfull (irq_rxfull),
  .irq_rxerr  (irq_rxerr),
  .irq_brk    (irq_brk)
);

// File: tb/serial_rx_fifo_bench.sv
`timescale 1ns/1ps
module serial_rx_fifo_bench;
  localparam int BIT = 16;

  logic clk, rst_n, sample_en, rxd_i;
  logic cfg_len8, cfg_par_en, cfg_par_odd, cfg_stop2;
  logic [1:0] cfg_trig;
  logic ie_rx, ie_err, rd_en, clr_err, clr_brk, clr_ovr;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr;
  logic [4:0] fifo_count;
  logic st_ready, st_full, st_err, st_brk, st_ovr;
  logic irq_rxfull, irq_rxerr, irq_brk;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  serial_rx_fifo u_serial_rx_fifo (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd_i(rxd_i),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_trig(cfg_trig), .ie_rx(ie_rx), .ie_err(ie_err),
    .rd_en(rd_en), .clr_err(clr_err), .clr_brk(clr_brk), .clr_ovr(clr_ovr),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .fifo_count(fifo_count), .st_ready(st_ready), .st_full(st_full),
    .st_err(st_err), .st_brk(st_brk), .st_ovr(st_ovr),
    .irq_rxfull(irq_rxfull), .irq_rxerr(irq_rxerr), .irq_brk(irq_brk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic len8, input logic odd);
    return (len8 ? ^d : ^d[6:0]) ^ odd;
  endfunction

  task automatic send_bit(input logic b);
    rxd_i = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pb, input logic s1, input logic s2);
    send_bit(1'b0);
    for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) send_bit(d[i]);
    if (cfg_par_en) send_bit(pb);
    send_bit(s1);
    if (cfg_stop2) send_bit(s2);
    rxd_i = 1'b1;
  endtask

  task automatic send_good(input logic [7:0] d);
    send_frame(d, par_bit(d, cfg_len8, cfg_par_odd), 1'b1, 1'b1);
  endtask

  task automatic idle_bits(input int n);
    rxd_i = 1'b1;
    repeat (n * BIT) @(negedge clk);
  endtask

  task automatic pop;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_clr(input int which);
    clr_err = (which == 0);
    clr_brk = (which == 1);
    clr_ovr = (which == 2);
    @(negedge clk);
    clr_err = 1'b0; clr_brk = 1'b0; clr_ovr = 1'b0;
    @(negedge clk);
  endtask

  // irq sweep over all enable combinations, expected from bench flag model
  task automatic irq_sweep(input logic e_full, input logic e_ready, input logic e_err,
                           input logic e_bo);
    for (int k = 0; k < 4; k++) begin
      ie_rx  = k[0];
      ie_err = k[1];
      #1;
      check("R10 irq_rxfull", irq_rxfull, k[0] & (e_full | e_ready));
      check("R11 irq_rxerr",  irq_rxerr,  (k[0] | k[1]) & e_err);
      check("R12 irq_brk",    irq_brk,    (k[0] | k[1]) & e_bo);
    end
    ie_rx = 1'b0; ie_err = 1'b0;
  endtask

  function automatic int lvl(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] expq[$];
    rst_n = 1'b0; sample_en = 1'b1; rxd_i = 1'b1;
    cfg_len8 = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    cfg_trig = 2'd0; ie_rx = 1'b0; ie_err = 1'b0; rd_en = 1'b0;
    clr_err = 1'b0; clr_brk = 1'b0; clr_ovr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 count", fifo_count, 0);
    check("R1 flags", {st_ready, st_full, st_err, st_brk, st_ovr}, 0);
    check("R1 irqs", {irq_rxfull, irq_rxerr, irq_brk}, 0);

    // R3 false start: short low pulse
    rxd_i = 1'b0;
    repeat (4) @(negedge clk);
    idle_bits(12);
    check("R3 false start count", fifo_count, 0);
    check("R3 false start flags", {st_err, st_brk, st_ovr}, 0);

    // R2 exhaustive 8N1 sweep
    for (int v = 0; v < 256; v++) begin
      send_good(8'(v));
      if (v < 4) check("R9 ready low at stop end", st_ready, 0);
      repeat (40) @(negedge clk);
      check("R2 count 8N1", fifo_count, 1);
      check("R2 data 8N1", rd_data, v);
      if (v < 4) begin
        check("R9 ready after idle", st_ready, 1);
        irq_sweep(1'b1, 1'b1, 1'b0, 1'b0);
      end
      pop();
      check("R13 count after pop", fifo_count, 0);
    end
    check("R4 no errors in sweep", st_err, 0);

    // R2 R4 seven bits, even parity, two stop bits
    cfg_len8 = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b1;
    for (int v = 0; v < 128; v++) begin
      send_good(8'(v) | 8'h80);
      repeat (8) @(negedge clk);
      check("R2 data 7E2", rd_data, v);
      check("R4 perr 7E2", rd_perr, 0);
      pop();
    end
    check("R4 err flag clear 7E2", st_err, 0);

    // R4 odd parity mismatch then a good frame
    cfg_len8 = 1'b1; cfg_par_odd = 1'b1; cfg_stop2 = 1'b0;
    send_frame(8'h5A, ~par_bit(8'h5A, 1'b1, 1'b1), 1'b1, 1'b1);
    send_good(8'hA7);
    idle_bits(3);
    check("R4 count after bad parity", fifo_count, 2);
    check("R4 bad entry data", rd_data, 8'h5A);
    check("R4 bad entry perr", rd_perr, 1);
    check("R4 err flag", st_err, 1);
    irq_sweep(1'b1, 1'b1, 1'b1, 1'b0);
    pop();
    check("R4 next entry data", rd_data, 8'hA7);
    check("R4 next entry perr", rd_perr, 0);
    pop();
    pulse_clr(0);
    check("R11 err cleared", st_err, 0);

    // R5 framing: first stop bit 0
    cfg_par_en = 1'b0;
    send_frame(8'h81, 1'b0, 1'b0, 1'b1);
    idle_bits(12);
    check("R5 ferr count", fifo_count, 1);
    check("R5 ferr entry", rd_ferr, 1);
    check("R5 ferr data", rd_data, 8'h81);
    check("R5 err flag", st_err, 1);
    pop();
    pulse_clr(0);
    // R5 second stop bit 0 is ignored
    cfg_stop2 = 1'b1;
    send_frame(8'h3C, 1'b0, 1'b1, 1'b0);
    idle_bits(12);
    check("R5 stop2 count", fifo_count, 1);
    check("R5 stop2 ferr", rd_ferr, 0);
    check("R5 stop2 err flag", st_err, 0);
    pop();
    cfg_stop2 = 1'b0;

    // R6 break
    send_frame(8'h00, 1'b0, 1'b0, 1'b0);
    rxd_i = 1'b0;
    repeat (BIT) @(negedge clk);
    idle_bits(12);
    check("R6 brk flag", st_brk, 1);
    check("R6 break not stored", fifo_count, 0);
    irq_sweep(1'b0, 1'b0, 1'b0, 1'b1);
    send_good(8'h11);
    idle_bits(2);
    check("R6 discarded while brk", fifo_count, 0);
    pulse_clr(1);
    check("R6 brk cleared", st_brk, 0);
    send_good(8'h22);
    idle_bits(2);
    check("R6 stored after clear", fifo_count, 1);
    check("R6 data after clear", rd_data, 8'h22);
    pop();
    pulse_clr(0);

    // R7 R8 fill, trigger levels, overrun
    for (int c = 0; c < 4; c++) begin
      cfg_trig = 2'(c); #1;
      check("R8 full when empty", st_full, 0);
    end
    for (int i = 0; i < 16; i++) begin
      send_good(8'(8'h40 + i));
      expq.push_back(8'(8'h40 + i));
      repeat (4) @(negedge clk);
      check("R7 fill count", fifo_count, i + 1);
      for (int c = 0; c < 4; c++) begin
        cfg_trig = 2'(c); #1;
        check("R8 trigger level", st_full, int'((i + 1) >= lvl(c)));
      end
    end
    cfg_trig = 2'd3;
    send_good(8'hEE);
    idle_bits(2);
    check("R7 ovr flag", st_ovr, 1);
    check("R7 count held", fifo_count, 16);
    irq_sweep(1'b1, 1'b1, 1'b0, 1'b1);
    check("R7 head intact", rd_data, 8'h40);
    pop();
    void'(expq.pop_front());
    send_good(8'hEF);
    idle_bits(2);
    check("R7 discarded while ovr", fifo_count, 15);
    pulse_clr(2);
    check("R7 ovr cleared", st_ovr, 0);
    send_good(8'hF0);
    expq.push_back(8'hF0);
    idle_bits(2);
    check("R7 stored after clear", fifo_count, 16);
    for (int i = 0; i < 16; i++) begin
      check("R13 order", rd_data, expq[i]);
      pop();
    end
    check("R13 drained", fifo_count, 0);
    pop();
    check("R13 pop on empty", fifo_count, 0);
    send_good(8'h99);
    idle_bits(1);
    check("R13 data after empty pop", rd_data, 8'h99);
    check("R13 count after empty pop", fifo_count, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule